// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous binary up-counter, four bits wide by default, that advances on the rising clock edge. Each clock cycle the block picks one of four operations: clear, load, count or hold. All count bits come from one register, so they change together and never ripple. An active-low load copies a data word into the count. Two active-high enables must both be high for the count to advance.

A carry output is high when the count sits at its all-ones value and the chain enable is high. The local enable plays no part in the carry. Stages are cascaded by driving the chain enable of each stage from the carry of the stage below. A build parameter fixes the clear behaviour. In one variant a low clear zeroes the register at once, with no clock. In the other it zeroes the register at the next rising edge. The synchronous variant lets one decode gate on the count outputs shorten the count cycle.

The operation is an enumerated value decoded each cycle. The operations are OP_CLEAR (clear low), OP_LOAD (load low, clear high), OP_COUNT (both enables high, load and clear high) and OP_HOLD (anything else). The priority is fixed: clear, then load, then count. The transitions are the register updates at each edge: zero, data word, count plus one modulo 2^WIDTH, or unchanged.

Top module: `presettable_counter`

## Requirements
- R1: All count bits are updated together on the rising clock edge from one register. Apart from asynchronous clear, count_q changes only at rising edges.
- R2: With clear_n high and load_n low at a rising edge, count_q takes data_in, whatever cnt_en and chain_en are.
- R3: With clear_n and load_n high and both cnt_en and chain_en high at a rising edge, count_q increments by one.
- R4: carry_out is 1 exactly when chain_en is 1 and count_q is all ones (4'b1111 by default). It does not depend on cnt_en.
- R5: With ASYNC_CLEAR=1, a low clear_n zeroes count_q immediately, without a clock edge. This overrides load and both enables.
- R6: With ASYNC_CLEAR=0, a low clear_n at a rising edge zeroes count_q at that edge. This takes priority over a low load_n and over the enables.
- R7: A pulse on load_n, or a synchronous-mode pulse on clear_n, that starts and ends between two rising edges leaves count_q unchanged.
- R8: Counting from all ones wraps count_q to zero.
- R9: With clear_n and load_n high and either enable low at a rising edge, count_q holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear; timing chosen by ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Local count enable; does not affect the carry |
| chain_en | input | 1 | Cascade count enable; also gates the carry |
| data_in | input | WIDTH | Value copied in on load |
| count_q | output | WIDTH | Registered count |
| carry_out | output | 1 | High when chain_en is high and the count is all ones |

## Verification
The state is one registered count, and every operation is visible on count_q in the cycle after the edge that applies it. A wrong operation choice therefore shows on count_q within one clock. A stuck or corrupted bit also shows on carry_out when the all-ones value is missed or reached too early. The bench builds both clear variants side by side, so a clear arriving at the wrong time shows between edges as a difference between the two. A priority inversion between clear and load shows at the first edge where both are low.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;
endpackage

// File: rtl/pcnt_op_select.sv
module pcnt_op_select
    import pcnt_pkg::*;
(
    input  logic clear_n,
    input  logic load_n,
    input  logic cnt_en,
    input  logic chain_en,
    output op_e  op
);
    // Fixed priority: clear, then load, then count, else hold
    always_comb begin
        if (!clear_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (cnt_en && chain_en)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/pcnt_next_value.sv
module pcnt_next_value
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = data;
            OP_COUNT: nxt = cur + ONE;
            OP_HOLD:  nxt = cur;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/pcnt_carry_decode.sv
module pcnt_carry_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             chain_en,
    output logic             carry
);
    localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};

    always_comb carry = chain_en && (count == TERMINAL);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import pcnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] count_q,
    output logic             carry_out
);
    op_e              op;
    logic [WIDTH-1:0] count_r;
    logic [WIDTH-1:0] count_nxt;
    logic             carry_w;

    pcnt_op_select u_sel (
        .clear_n (clear_n),
        .load_n  (load_n),
        .cnt_en  (cnt_en),
        .chain_en(chain_en),
        .op      (op)
    );

    pcnt_next_value #(.WIDTH(WIDTH)) u_next (
        .op  (op),
        .cur (count_r),
        .data(data_in),
        .nxt (count_nxt)
    );

    pcnt_carry_decode #(.WIDTH(WIDTH)) u_carry (
        .count   (count_r),
        .chain_en(chain_en),
        .carry   (carry_w)
    );

    // State register: clear timing chosen at build time
    generate
        if (ASYNC_CLEAR) begin : g_async_clr
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n)
                    count_r <= '0;
                else
                    count_r <= count_nxt;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                count_r <= count_nxt;
            end
        end
    endgenerate

    // Outputs
    always_comb begin
        count_q   = count_r;
        carry_out = carry_w;
    end
endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input logic             clk,
    input logic             clear_n,
    input logic             load_n,
    input logic             cnt_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] data_in,
    input logic [WIDTH-1:0] count_q,
    input logic             carry_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic armed = 1'b0;
    always @(posedge clk) if (!clear_n) armed <= 1'b1;

    a_r2_load_takes_data: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && !load_n) |=> (count_q == $past(data_in)) || (ASYNC_CLEAR && count_q == '0));

    a_r3_increments: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && cnt_en && chain_en)
            |=> (count_q == WIDTH'($past(count_q) + 1'b1)) || (ASYNC_CLEAR && count_q == '0));

    a_r4_carry_needs_terminal: assert property (@(posedge clk) disable iff (!armed)
        carry_out |-> (chain_en && count_q == ALL_ONES));

    a_r4_no_carry_without_chain: assert property (@(posedge clk) disable iff (!armed)
        !chain_en |-> !carry_out);

    a_r5_async_zero: assert property (@(posedge clk) disable iff (!armed)
        (ASYNC_CLEAR && !clear_n) |-> count_q == '0);

    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!armed)
        !clear_n |=> count_q == '0);

    a_r9_holds: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && !(cnt_en && chain_en))
            |=> $stable(count_q) || (ASYNC_CLEAR && count_q == '0));
endmodule

bind presettable_counter presettable_counter_chk #(
    .WIDTH      (WIDTH),
    .ASYNC_CLEAR(ASYNC_CLEAR)
) u_chk (
    .clk      (clk),
    .clear_n  (clear_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .data_in  (data_in),
    .count_q  (count_q),
    .carry_out(carry_out)
);

// File: tb/presettable_counter_tb_top.sv
module presettable_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int MODV = 1 << W;

    logic         clk = 1'b0;
    logic         clear_n = 1'b0;
    logic         load_n = 1'b1;
    logic         cnt_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] cnt_a, cnt_s;
    logic         cy_a, cy_s;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_a   = 0;
    int exp_s   = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    presettable_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b1)) dut_i (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .data_in(data_in), .count_q(cnt_a), .carry_out(cy_a));

    presettable_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b0)) dut_s_i (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .data_in(data_in), .count_q(cnt_s), .carry_out(cy_s));

    // Behavioural reference model
    function automatic int model_next(int c);
        if (!clear_n)              return 0;
        if (!load_n)               return int'(data_in);
        if (cnt_en && chain_en)    return (c + 1) % MODV;
        return c;
    endfunction

    always @(posedge clk) begin
        exp_a <= model_next(exp_a);
        exp_s <= model_next(exp_s);
    end
    always @(negedge clear_n) exp_a <= 0;

    task automatic chk(string req, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic compare(string req);
        chk({req, " async count"}, int'(cnt_a), exp_a);
        chk({req, " sync count"},  int'(cnt_s), exp_s);
        chk({req, " async carry"}, int'(cy_a), int'(chain_en && exp_a == MODV-1));
        chk({req, " sync carry"},  int'(cy_s), int'(chain_en && exp_s == MODV-1));
    endtask

    task automatic tick(string req);
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // Reset through clear (R5, R6)
        tick("R6 reset");
        tick("R5 reset");
        clear_n = 1'b1;
        // Load with enables low, then high (R2)
        load_n = 1'b0; data_in = 4'hA;
        tick("R2 load enables low");
        cnt_en = 1'b1; chain_en = 1'b1; data_in = 4'h3;
        tick("R2 load enables high");
        // Count up through wrap (R3, R8, R4)
        load_n = 1'b0; data_in = 4'hC;
        tick("R2 load C");
        load_n = 1'b1;
        for (int i = 0; i < 6; i++) tick("R3 R8 R4 count and wrap");
        // Hold with each enable low (R9), carry independent of local enable (R4)
        load_n = 1'b0; data_in = 4'hF;
        tick("R2 load F");
        load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b1;
        tick("R9 hold local low, R4 carry high");
        tick("R9 hold local low");
        cnt_en = 1'b1; chain_en = 1'b0;
        tick("R9 hold chain low, R4 carry low");
        // Load pulse between edges (R7)
        load_n = 1'b0; data_in = 4'h5;
        #(CLK_PERIOD/5);
        load_n = 1'b1;
        tick("R7 load pulse between edges");
        // Clear pulse between edges: async zeroes at once, sync ignores (R5, R7)
        clear_n = 1'b0;
        #(CLK_PERIOD/5);
        chk("R5 async immediate zero", int'(cnt_a), 0);
        chk("R7 sync unchanged mid-cycle", int'(cnt_s), 15);
        clear_n = 1'b1;
        tick("R7 R5 after clear pulse");
        // Clear beats load and enables (R6)
        load_n = 1'b0; data_in = 4'h9;
        tick("R2 load 9");
        cnt_en = 1'b1; chain_en = 1'b1; clear_n = 1'b0;
        tick("R6 clear over load");
        clear_n = 1'b1; load_n = 1'b1;
        tick("R3 count after clear");
        tick("R1 synchronous update");
        // Pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            clear_n  = (lfsr[3:0] != 4'd0);
            load_n   = (lfsr[6:4] != 3'd0);
            cnt_en   = lfsr[7] | lfsr[8];
            chain_en = lfsr[9] | lfsr[10];
            data_in  = lfsr[14:11];
            tick("R1 R3 R9 mixed traffic");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule